// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This block takes a received packet byte stream and stores it in memory buffers. A ring of 8-byte descriptors in memory describes those buffers. When the first byte of a buffer's worth of data arrives, the block reads the descriptor at its current pointer. If the descriptor is free, the block takes the buffer address from it and packs the bytes into 32-bit little-endian word writes that carry byte enables. It then closes the buffer by writing the byte count and the updated status back into the descriptor.

A buffer closes for one of three reasons: its byte count reaches the maximum length, the packet ends, or the stream flags an error. When a buffer fills before the packet ends, the rest of the packet goes into the next descriptor. The pointer moves on by one descriptor after each close. It returns to the ring base after a descriptor whose wrap bit is set. Software sets the ring base and the maximum length. It may place the pointer directly only while no buffer is open or the block is disabled.

Top module: `rxbd_dma`

## Requirements
- R1: After reset, `cur_ptr_o` is 0 and `mem_req_o`, `rx_ready_o` and `busy_o` are low.
- R2: The descriptor at pointer P is read as the word at P, followed by the buffer address in the word at P+4. The word at P holds status in bits 15:0 and length in bits 31:16. Status bit 15 is empty and status bit 13 is wrap.
- R3: Byte n of a buffer lands at buffer address + n, with the buffer address a multiple of 4. Bytes are packed little-endian and each word write enables only the lanes written. Bytes beyond the count are left untouched.
- R4: A buffer closes when its count reaches the maximum length latched at the descriptor read. If the packet has not ended, it continues in the next descriptor, and the closed status has both bit 11 and bit 1 clear.
- R5: A change to `max_len_i` while a buffer is open applies from the next descriptor on.
- R6: On end-of-packet, the block writes the count into bits 31:16 of the descriptor and clears empty. It sets last (status bit 11) and keeps every other status bit.
- R7: A byte flagged with `rx_err_i` is stored and counted, then the buffer closes with error (status bit 1) set and last clear.
- R8: After a close, the pointer advances by 8, or reloads `ring_base_i` if the closed descriptor had wrap set.
- R9: A descriptor read with empty clear raises `busy_o` for one cycle. The bytes are then discarded up to and including the next end-of-packet or error. The pointer and the descriptor stay unchanged.
- R10: `ptr_load_i` loads `ptr_val_i` when `enable_i` is low or no descriptor is being processed. Otherwise it is ignored.
- R11: No memory request is issued while `rx_ready_o` is high, and every write request has a nonzero byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Receiver enable; a new descriptor starts only when high |
| ring_base_i | input | AW | Ring base address, multiple of 8 |
| max_len_i | input | 16 | Maximum buffer length, multiple of 4 |
| ptr_load_i | input | 1 | Pointer load strobe |
| ptr_val_i | input | AW | Value for pointer load |
| cur_ptr_o | output | AW | Current descriptor pointer |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_eop_i | input | 1 | Byte is the last of the packet |
| rx_err_i | input | 1 | Byte ends the packet with an error |
| rx_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| busy_o | output | 1 | Pulse: descriptor not free, packet dropped |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The bench builds the block with AW = 16, a four-descriptor ring and a small memory with a one-cycle read latency. It sweeps packet lengths from 1 to 13 with a maximum length of 8, and from 1 to 9 with a maximum length of 4. These sweeps cover every byte-lane end position, the exact-fit case and multi-descriptor spills, and they wrap the ring several times. Directed packets add an error ending, a maximum-length change in the middle of a packet, a descriptor that is not free, and pointer loads during idle, while disabled, and in the middle of a packet.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int NLANE = 4;
  localparam int DW    = 8 * NLANE;
  localparam int LENW  = 16;
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_LAST  = 11;
  localparam int ST_ERR   = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD0W, S_RD1, S_RD1W, S_RECV, S_WRDAT, S_WBST, S_DROP
  } state_e;
endpackage

// File: rtl/rxbd_pack.sv
module rxbd_pack #(
  parameter int NLANE = 4,
  localparam int LW = $clog2(NLANE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 put_i,
  input  logic [LW-1:0]        lane_i,
  input  logic [7:0]           data_i,
  input  logic                 clr_i,
  output logic [8*NLANE-1:0]   word_o,
  output logic [NLANE-1:0]     be_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[8*g +: 8] <= '0;
        be_o[g]          <= 1'b0;
      end else if (clr_i) begin
        be_o[g] <= 1'b0;
      end else if (put_i && lane_i == LW'(g)) begin
        word_o[8*g +: 8] <= data_i;
        be_o[g]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxbd_ptr.sv
module rxbd_ptr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (adv_i)  ptr_o <= wrap_i ? base_i : ptr_o + STEP;
  end
endmodule

// File: rtl/rxbd_dma.sv
module rxbd_dma
  import rxbd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [AW-1:0]      ring_base_i,
  input  logic [LENW-1:0]    max_len_i,
  input  logic               ptr_load_i,
  input  logic [AW-1:0]      ptr_val_i,
  output logic [AW-1:0]      cur_ptr_o,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_eop_i,
  input  logic               rx_err_i,
  output logic               rx_ready_o,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic [NLANE-1:0]   mem_be_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [DW-1:0]      mem_rdata_i
);
  localparam int LW = $clog2(NLANE);
  localparam logic [LW-1:0] LANE_TOP = LW'(NLANE - 1);
  localparam logic [LENW-1:0] WMASK = ~LENW'(NLANE - 1);

  state_e            state_q, state_d;
  logic [15:0]       stat_q;
  logic [LENW-1:0]   max_q, cnt_q, cnt_inc, cnt_m1;
  logic [AW-1:0]     buf_q, wr_addr;
  logic              close_last_q, close_err_q, closing_q;
  logic              full, end_word;
  logic              pk_put, pk_clr, ptr_adv, ptr_load;
  logic [DW-1:0]     pk_word;
  logic [NLANE-1:0]  pk_be;
  logic [15:0]       stat_new;

  assign cnt_inc  = cnt_q + LENW'(1);
  assign cnt_m1   = cnt_q - LENW'(1);
  assign full     = (cnt_inc == max_q);
  assign end_word = (cnt_q[LW-1:0] == LANE_TOP);
  assign wr_addr  = buf_q + AW'(cnt_m1 & WMASK);
  assign ptr_load = ptr_load_i && (!enable_i || state_q == S_IDLE);

  always_comb begin
    stat_new           = stat_q;
    stat_new[ST_EMPTY] = 1'b0;
    stat_new[ST_LAST]  = close_last_q;
    stat_new[ST_ERR]   = close_err_q;
  end

  rxbd_pack #(.NLANE(NLANE)) pack_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .put_i  (pk_put),
    .lane_i (cnt_q[LW-1:0]),
    .data_i (rx_data_i),
    .clr_i  (pk_clr),
    .word_o (pk_word),
    .be_o   (pk_be)
  );

  rxbd_ptr #(.AW(AW)) ptr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_val_i),
    .adv_i      (ptr_adv),
    .wrap_i     (stat_q[ST_WRAP]),
    .base_i     (ring_base_i),
    .ptr_o      (cur_ptr_o)
  );

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_ptr_o;
    mem_wdata_o = pk_word;
    mem_be_o    = pk_be;
    rx_ready_o  = 1'b0;
    busy_o      = 1'b0;
    pk_put      = 1'b0;
    pk_clr      = 1'b0;
    ptr_adv     = 1'b0;
    unique case (state_q)
      S_IDLE: if (enable_i && rx_valid_i) state_d = S_RD0;
      S_RD0: begin
        mem_req_o = 1'b1;
        if (mem_gnt_i) state_d = S_RD0W;
      end
      S_RD0W: if (mem_rvalid_i) begin
        if (mem_rdata_i[ST_EMPTY]) state_d = S_RD1;
        else begin
          busy_o  = 1'b1;
          state_d = S_DROP;
        end
      end
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_ptr_o + AW'(4);
        if (mem_gnt_i) state_d = S_RD1W;
      end
      S_RD1W: if (mem_rvalid_i) state_d = S_RECV;
      S_RECV: begin
        rx_ready_o = 1'b1;
        if (rx_valid_i) begin
          pk_put = 1'b1;
          if (end_word || rx_eop_i || rx_err_i || full) state_d = S_WRDAT;
        end
      end
      S_WRDAT: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = wr_addr;
        if (mem_gnt_i) begin
          pk_clr  = 1'b1;
          state_d = closing_q ? S_WBST : S_RECV;
        end
      end
      S_WBST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {cnt_q, stat_new};
        mem_be_o    = '1;
        if (mem_gnt_i) begin
          ptr_adv = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_DROP: begin
        rx_ready_o = 1'b1;
        if (rx_valid_i && (rx_eop_i || rx_err_i)) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      stat_q       <= '0;
      max_q        <= '0;
      cnt_q        <= '0;
      buf_q        <= '0;
      close_last_q <= 1'b0;
      close_err_q  <= 1'b0;
      closing_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_RD0W && mem_rvalid_i && mem_rdata_i[ST_EMPTY]) begin
        stat_q <= mem_rdata_i[15:0];
        max_q  <= max_len_i;  // latched per descriptor
      end
      if (state_q == S_RD1W && mem_rvalid_i) begin
        buf_q        <= AW'(mem_rdata_i);
        cnt_q        <= '0;
        close_last_q <= 1'b0;
        close_err_q  <= 1'b0;
        closing_q    <= 1'b0;
      end
      if (state_q == S_RECV && rx_valid_i) begin
        cnt_q     <= cnt_inc;
        closing_q <= rx_eop_i || rx_err_i || full;
        if (rx_eop_i) close_last_q <= 1'b1;
        if (rx_err_i) close_err_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxbd_dma_chk.sv
module rxbd_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          ptr_load_i,
  input logic [AW-1:0] cur_ptr_o,
  input logic          rx_ready_o,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [3:0]    mem_be_o
);
  // R11
  be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_be_o != 4'h0);

  // R11
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !mem_req_o);

  // R10
  load_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i && enable_i && rx_ready_o |=> $stable(cur_ptr_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && enable_i |=> $stable(cur_ptr_o));

  // R9
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rx_ready_o && !mem_req_o);
endmodule

bind rxbd_dma rxbd_dma_chk #(.AW(AW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .ptr_load_i (ptr_load_i),
  .cur_ptr_o  (cur_ptr_o),
  .rx_ready_o (rx_ready_o),
  .busy_o     (busy_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_be_o   (mem_be_o)
);

// File: tb/rxbd_dma_tb_top.sv
module rxbd_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int NDSC = 4;
  localparam logic [AW-1:0] RING = 16'h0040;
  localparam logic [AW-1:0] BUFB = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic [15:0] max_len = 16'd8;
  logic ptr_load = 1'b0;
  logic [AW-1:0] ptr_val = '0;
  logic [AW-1:0] cur_ptr;
  logic rx_valid = 1'b0, rx_eop = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, busy;
  logic mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic mem_gnt;
  assign mem_gnt = 1'b1;

  logic [31:0] mem [256];
  int checks = 0, errors = 0, busy_cnt = 0, r11_viol = 0, fno = 0, idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbd_dma #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ring_base_i(RING),
    .max_len_i(max_len), .ptr_load_i(ptr_load), .ptr_val_i(ptr_val),
    .cur_ptr_o(cur_ptr), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_eop_i(rx_eop), .rx_err_i(rx_err), .rx_ready_o(rx_ready), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && !mem_we) begin
      mem_rdata  <= mem[mem_addr[9:2]];
      mem_rvalid <= 1'b1;
    end
    if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (busy) busy_cnt <= busy_cnt + 1;
    if (rst_n && ((mem_req && rx_ready) || (mem_req && mem_we && mem_be == 4'h0)))
      r11_viol <= r11_viol + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] dsc(input int i);
    return RING + AW'(8 * i);
  endfunction
  function automatic logic [AW-1:0] bufa(input int i);
    return BUFB + AW'(64 * i);
  endfunction
  function automatic logic [15:0] sbase(input int i);
    return 16'h8004 | ((i == NDSC - 1) ? 16'h2000 : 16'h0000);
  endfunction
  function automatic logic [7:0] rdb(input logic [AW-1:0] a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic arm();
    for (int i = 0; i < NDSC; i++) begin
      mem[dsc(i) >> 2]       = {16'h0000, sbase(i)};
      mem[(dsc(i) >> 2) + 1] = {16'h0000, bufa(i)};
      for (int w = 0; w < 16; w++) mem[(bufa(i) >> 2) + w] = 32'hEEEE_EEEE;
    end
  endtask

  task automatic send(input int len, input bit err, input int chg_at,
                      input logic [15:0] m2, input int load_at);
    logic [7:0] seed = 8'(fno * 37);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = seed + 8'(k);
      rx_eop   = (k == len - 1) && !err;
      rx_err   = (k == len - 1) && err;
      if (k == chg_at) max_len = m2;
      ptr_load = (k == load_at);
      ptr_val  = RING;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eop = 1'b0; rx_err = 1'b0; ptr_load = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic frame(input int len, input bit err, input int m1, input int m2,
                       input int chg_at, input int load_at, input string tag);
    int rem = len, k = 0, lim, n;
    bit first = 1'b1, fin, ok;
    logic [15:0] st;
    logic [7:0] seed = 8'(fno * 37);
    max_len = 16'(m1);
    arm();
    send(len, err, chg_at, 16'(m2), load_at);
    while (rem > 0) begin
      lim = first ? m1 : m2;
      n   = (rem < lim) ? rem : lim;
      fin = (rem == n);
      st  = sbase(idx) & 16'h7FFF;
      if (fin) st = st | (err ? 16'h0002 : 16'h0800);
      chk(mem[dsc(idx) >> 2] == {16'(n), st},
          fin ? (err ? "R7 close" : "R6 close") : {tag, " R4 full close"},
          mem[dsc(idx) >> 2], {16'(n), st});
      ok = 1'b1;
      for (int j = 0; j < n; j++)
        if (rdb(bufa(idx) + AW'(j)) != seed + 8'(k + j)) ok = 1'b0;
      chk(ok, "R2 R3 buffer data", 32'(len), 32'(n));
      if (n % 4 != 0)
        chk(rdb(bufa(idx) + AW'(n)) == 8'hEE, "R3 untouched lane",
            32'(rdb(bufa(idx) + AW'(n))), 32'hEE);
      k += n; rem -= n; first = 1'b0;
      idx = (idx == NDSC - 1) ? 0 : idx + 1;
    end
    chk(cur_ptr == dsc(idx), "R8 pointer", 32'(cur_ptr), 32'(dsc(idx)));
    fno++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'(0), 32'(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b0;
    logic [31:0] w0;
    repeat (3) @(negedge clk);
    chk(cur_ptr == '0, "R1 ptr", 32'(cur_ptr), 0);
    chk(!mem_req && !rx_ready && !busy, "R1 outputs", {mem_req, rx_ready, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_ptr == '0 && !mem_req, "R1 after release", 32'(cur_ptr), 0);

    // R10 idle load
    ptr_load = 1'b1; ptr_val = RING; @(negedge clk); ptr_load = 1'b0;
    chk(cur_ptr == RING, "R10 idle load", 32'(cur_ptr), 32'(RING));
    idx = 0;

    for (int len = 1; len <= 13; len++) frame(len, (len % 4) == 3, 8, 8, -1, -1, "R4");
    for (int len = 1; len <= 9; len++)  frame(len, len == 6, 4, 4, -1, -1, "R4");

    // R5 max change mid-buffer
    frame(12, 1'b0, 8, 4, 2, -1, "R5");
    frame(6, 1'b0, 4, 4, -1, -1, "R5");

    // R9 descriptor not free
    max_len = 16'd8;
    arm();
    mem[dsc(idx) >> 2] = {16'h0000, sbase(idx) & 16'h7FFF};
    w0 = mem[dsc(idx) >> 2];
    b0 = busy_cnt;
    send(5, 1'b0, -1, 16'd8, -1);
    chk(busy_cnt == b0 + 1, "R9 busy pulse", 32'(busy_cnt - b0), 1);
    chk(cur_ptr == dsc(idx), "R9 ptr held", 32'(cur_ptr), 32'(dsc(idx)));
    chk(mem[dsc(idx) >> 2] == w0, "R9 descriptor kept", mem[dsc(idx) >> 2], w0);
    chk(rdb(bufa(idx)) == 8'hEE, "R9 buffer kept", 32'(rdb(bufa(idx))), 32'hEE);
    fno++;
    frame(3, 1'b0, 8, 8, -1, -1, "R9");

    // R10 load with receiver disabled
    enable = 1'b0;
    @(negedge clk); ptr_load = 1'b1; ptr_val = dsc(1); @(negedge clk); ptr_load = 1'b0;
    enable = 1'b1;
    chk(cur_ptr == dsc(1), "R10 disabled load", 32'(cur_ptr), 32'(dsc(1)));
    idx = 1;
    // R10 load ignored while a buffer is open
    frame(5, 1'b0, 8, 8, -1, 1, "R10");
    frame(10, 1'b1, 8, 8, -1, 3, "R10");

    chk(r11_viol == 0, "R11 memory port rules", 32'(r11_viol), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule